// File: doc/BRIEF.md
# Warp Divergence Mask Stack

This block keeps track of which lanes of a 32-lane warp are enabled while the warp runs through nested, data-dependent branches. Each conditional branch presents a per-lane taken vector and a target address. If the enabled lanes all agree, no state is saved. If every enabled lane takes the branch, the block issues a fetch redirect to the target. If the enabled lanes disagree, the block saves a record and narrows the mask to the lanes that fall through. Those lanes run first.

When the compiler-placed merge point is reached for the first time, the block switches the mask to the lanes that took the branch and redirects fetch to the saved target. At the second arrival at the same merge point it discards the record and restores the mask that was in force before the branch. Records nest, so an inner divergence is resolved before the outer one. A divergent branch that finds the record storage full sets a sticky error flag and changes nothing else. All outputs are registered, so the effect of an input is seen one cycle later.

Top module: `dms_reconv_stack`

## Requirements
- R1: After reset the active mask is all ones, redir_valid is 0 and ovf_err is 0.
- R2: A valid branch in which every enabled lane is taken gives redir_valid=1 with redir_pc equal to br_target in the next cycle. The mask stays the same and no record is saved.
- R3: A valid branch in which no enabled lane is taken changes nothing and gives no redirect. Taken bits on lanes that are not enabled are ignored.
- R4: A valid branch in which the enabled lanes disagree saves a record and, in the next cycle, sets the mask to the enabled lanes whose taken bit is 0. It gives no redirect. The mask is never zero.
- R5: The first merge signal for the top record sets the mask to the lanes that were taken at that branch and gives redir_valid=1 with redir_pc equal to the saved target.
- R6: The second merge signal for the top record removes the record and restores the mask that was active when the branch arrived. It gives no redirect.
- R7: Up to 8 divergent branches nest. Merges resolve the records in last-in, first-out order.
- R8: A divergent branch while 8 records are held sets ovf_err. The mask and the records are unchanged, and no redirect is given. ovf_err then stays 1 until reset.
- R9: A merge signal with no record held is ignored. With no record held the mask is all ones.
- R10: When br_valid and merge_valid are both high in one cycle, only the branch is acted on and the merge is ignored.
- R11: Every output changes only in the cycle after a qualifying input. redir_valid is a one-cycle pulse. With no branch and no merge input, the mask holds and redir_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally in step with the clock |
| br_valid | input | 1 | A conditional branch has been resolved this cycle |
| br_taken | input | 32 | Per-lane branch outcome (1 = taken) |
| br_target | input | 32 | Address of the branch target |
| merge_valid | input | 1 | The warp has reached a compiler-placed merge point |
| active_mask | output | 32 | Lanes currently enabled |
| redir_valid | output | 1 | One-cycle request to fetch from redir_pc |
| redir_pc | output | 32 | Redirect address; meaningful when redir_valid is 1 |
| ovf_err | output | 1 | Sticky flag: a divergent branch found the record storage full |

## Verification
The assertions assume that the branch and merge inputs are low while reset is held and that the upstream logic may assert merge_valid at any time. The block must stay safe even when no record exists. They also rely on the mask being non-empty, which holds only if a divergent split is applied to two non-empty lane groups. The stimulus holds both strobes low through reset and then applies one event per cycle. Taken vectors are drawn all-ones, all-zeros, random, or as a single flipped lane of the current mask, so both uniform and split outcomes occur often. The random phase also drives simultaneous branch and merge strobes, as well as merges against an empty store.

// File: rtl/dms_pkg.sv
package dms_pkg;
  // Outcome of a branch against the current active mask
  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,  // no branch, or no enabled lane taken
    CLS_UNIFORM = 2'd1,  // all enabled lanes taken
    CLS_SPLIT   = 2'd2   // enabled lanes disagree
  } br_class_e;
endpackage

// File: rtl/dms_rst_sync.sv
module dms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dms_lane_classify.sv
module dms_lane_classify
  import dms_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  logic             valid,
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] taken_act,
  output logic [LANES-1:0] fall_act,
  output br_class_e        cls
);
  assign taken_act = taken & active;
  assign fall_act  = ~taken & active;

  always_comb begin
    cls = CLS_NONE;
    if (valid) begin
      if ((taken_act != '0) && (fall_act != '0)) cls = CLS_SPLIT;
      else if (taken_act != '0)                   cls = CLS_UNIFORM;
    end
  end
endmodule

// File: rtl/dms_entry_stack.sv
module dms_entry_stack #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LANES-1:0] push_parent,
  input  logic [LANES-1:0] push_taken,
  input  logic [PC_W-1:0]  push_pc,
  input  logic             pop,
  input  logic             mark,
  output logic [LANES-1:0] top_parent,
  output logic [LANES-1:0] top_taken,
  output logic [PC_W-1:0]  top_pc,
  output logic             top_phase,
  output logic             empty,
  output logic             full
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [IDX_W-1:0] top_idx;

  logic [LANES-1:0] parent_arr [DEPTH];
  logic [LANES-1:0] taken_arr  [DEPTH];
  logic [PC_W-1:0]  pc_arr     [DEPTH];
  logic             phase_arr  [DEPTH];

  // Occupancy counter: next state
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = push | pop;
    if (push)     cnt_d = cnt_q + CNT_W'(1);
    else if (pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // One storage slot per level
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT = CNT_W'(g);
    logic             wr_en, mk_en;
    logic [LANES-1:0] parent_r, taken_r;
    logic [PC_W-1:0]  pc_r;
    logic             phase_r;

    assign wr_en = push && (cnt_q == SLOT);
    assign mk_en = mark && (cnt_q == SLOT + CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        parent_r <= '0;
        taken_r  <= '0;
        pc_r     <= '0;
      end else if (wr_en) begin
        parent_r <= push_parent;
        taken_r  <= push_taken;
        pc_r     <= push_pc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase_r <= 1'b0;
      else if (wr_en) phase_r <= 1'b0;
      else if (mk_en) phase_r <= 1'b1;
    end

    assign parent_arr[g] = parent_r;
    assign taken_arr[g]  = taken_r;
    assign pc_arr[g]     = pc_r;
    assign phase_arr[g]  = phase_r;
  end

  assign top_idx    = IDX_W'(cnt_q - CNT_W'(1));
  assign top_parent = parent_arr[top_idx];
  assign top_taken  = taken_arr[top_idx];
  assign top_pc     = pc_arr[top_idx];
  assign top_phase  = phase_arr[top_idx];
  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/dms_reconv_stack.sv
module dms_reconv_stack
  import dms_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic             merge_valid,
  output logic [LANES-1:0] active_mask,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic             ovf_err
);
  logic             rst_sync_n;
  logic [LANES-1:0] mask_q, mask_d;
  logic             mask_en;
  logic             rv_q, rv_d;
  logic [PC_W-1:0]  rpc_q, rpc_d;
  logic             ovf_q, ovf_d;

  logic [LANES-1:0] taken_act, fall_act;
  br_class_e        cls;

  logic             push, pop, mark;
  logic [LANES-1:0] top_parent, top_taken;
  logic [PC_W-1:0]  top_pc;
  logic             top_phase, stk_empty, stk_full;

  dms_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dms_lane_classify #(.LANES(LANES)) u_cls (
    .valid     (br_valid),
    .active    (mask_q),
    .taken     (br_taken),
    .taken_act (taken_act),
    .fall_act  (fall_act),
    .cls       (cls)
  );

  dms_entry_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_stk (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push        (push),
    .push_parent (mask_q),
    .push_taken  (taken_act),
    .push_pc     (br_target),
    .pop         (pop),
    .mark        (mark),
    .top_parent  (top_parent),
    .top_taken   (top_taken),
    .top_pc      (top_pc),
    .top_phase   (top_phase),
    .empty       (stk_empty),
    .full        (stk_full)
  );

  // Next-state logic: a branch wins over a merge in the same cycle
  always_comb begin
    push   = 1'b0;
    pop    = 1'b0;
    mark   = 1'b0;
    mask_d = mask_q;
    rv_d   = 1'b0;
    rpc_d  = rpc_q;
    ovf_d  = ovf_q;
    unique case (cls)
      CLS_SPLIT: begin
        if (stk_full) begin
          ovf_d = 1'b1;
        end else begin
          push   = 1'b1;
          mask_d = fall_act;
        end
      end
      CLS_UNIFORM: begin
        rv_d  = 1'b1;
        rpc_d = br_target;
      end
      default: begin
        if (!br_valid && merge_valid && !stk_empty) begin
          if (!top_phase) begin
            mark   = 1'b1;
            mask_d = top_taken;
            rv_d   = 1'b1;
            rpc_d  = top_pc;
          end else begin
            pop    = 1'b1;
            mask_d = top_parent;
          end
        end
      end
    endcase
    mask_en = push | pop | mark;
  end

  // State registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rv_q <= 1'b0;
    else             rv_q <= rv_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rpc_q <= '0;
    else if (rv_d)   rpc_q <= rpc_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovf_q <= 1'b0;
    else if (ovf_d)  ovf_q <= 1'b1;
  end

  assign active_mask = mask_q;
  assign redir_valid = rv_q;
  assign redir_pc    = rpc_q;
  assign ovf_err     = ovf_q;
endmodule

// File: rtl/dms_reconv_chk.sv
module dms_reconv_chk #(
  parameter int unsigned LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic             merge_valid,
  input logic [LANES-1:0] active_mask,
  input logic             redir_valid,
  input logic             ovf_err,
  input logic             stk_empty
);
  // R8: the overflow flag never clears once set
  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R11: no redirect pulse without a branch or merge strobe
  assert_no_spurious_redir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !merge_valid) |=> !redir_valid);

  // R11: the mask holds when no strobe is present
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !merge_valid) |=> $stable(active_mask));

  // R4: a split never leaves the warp without enabled lanes
  assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);

  // R3: a branch can only narrow the mask, never enable new lanes
  assert_branch_no_new_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> ((active_mask & ~$past(active_mask)) == '0));

  // R9: with no record held, every lane is enabled
  assert_empty_all_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_empty |-> (active_mask == '1));
endmodule

bind dms_reconv_stack dms_reconv_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .br_valid    (br_valid),
  .merge_valid (merge_valid),
  .active_mask (active_mask),
  .redir_valid (redir_valid),
  .ovf_err     (ovf_err),
  .stk_empty   (stk_empty)
);

// File: tb/dms_reconv_stack_bench.sv
`timescale 1ns/1ps
module dms_reconv_stack_bench;
  localparam int LANES = 32;
  localparam int DEPTH = 8;
  localparam int PC_W  = 32;

  logic             clk;
  logic             rst_n;
  logic             br_valid;
  logic [LANES-1:0] br_taken;
  logic [PC_W-1:0]  br_target;
  logic             merge_valid;
  logic [LANES-1:0] active_mask;
  logic             redir_valid;
  logic [PC_W-1:0]  redir_pc;
  logic             ovf_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  dms_reconv_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_dms_reconv_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .merge_valid (merge_valid),
    .active_mask (active_mask),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .ovf_err     (ovf_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model state
  logic [LANES-1:0] m_par [DEPTH];
  logic [LANES-1:0] m_tak [DEPTH];
  logic [PC_W-1:0]  m_pc  [DEPTH];
  bit               m_ph  [DEPTH];
  int               m_cnt;
  logic [LANES-1:0] m_mask;
  bit               m_rv;
  logic [PC_W-1:0]  m_rpc;
  bit               m_ovf;

  task automatic model_reset();
    m_cnt  = 0;
    m_mask = '1;
    m_rv   = 0;
    m_rpc  = '0;
    m_ovf  = 0;
  endtask

  task automatic model_step(input bit bv, input logic [LANES-1:0] bt,
                            input logic [PC_W-1:0] tgt, input bit mv);
    logic [LANES-1:0] ta, fa;
    ta   = bt & m_mask;
    fa   = ~bt & m_mask;
    m_rv = 0;
    if (bv) begin
      if (ta != '0 && fa != '0) begin
        if (m_cnt == DEPTH) m_ovf = 1;
        else begin
          m_par[m_cnt] = m_mask;
          m_tak[m_cnt] = ta;
          m_pc[m_cnt]  = tgt;
          m_ph[m_cnt]  = 0;
          m_cnt++;
          m_mask = fa;
        end
      end else if (ta != '0) begin
        m_rv  = 1;
        m_rpc = tgt;
      end
    end else if (mv && m_cnt > 0) begin
      if (!m_ph[m_cnt-1]) begin
        m_ph[m_cnt-1] = 1;
        m_mask = m_tak[m_cnt-1];
        m_rv   = 1;
        m_rpc  = m_pc[m_cnt-1];
      end else begin
        m_mask = m_par[m_cnt-1];
        m_cnt--;
      end
    end
  endtask

  task automatic check(input string tag);
    bit bad;
    n_tests++;
    bad = (active_mask !== m_mask) || (redir_valid !== m_rv) ||
          (ovf_err !== m_ovf) || (m_rv && (redir_pc !== m_rpc));
    if (bad) begin
      n_fail++;
      $display("FAIL %s: mask=%h exp=%h rv=%b exp=%b pc=%h exp=%h ovf=%b exp=%b",
               tag, active_mask, m_mask, redir_valid, m_rv, redir_pc, m_rpc,
               ovf_err, m_ovf);
    end
  endtask

  // Apply one event at a falling edge, check after the next rising edge
  task automatic step(input bit bv, input logic [LANES-1:0] bt,
                      input logic [PC_W-1:0] tgt, input bit mv, input string tag);
    br_valid    = bv;
    br_taken    = bt;
    br_target   = tgt;
    merge_valid = mv;
    model_step(bv, bt, tgt, mv);
    @(negedge clk);
    check(tag);
    br_valid    = 0;
    merge_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; br_valid = 0; merge_valid = 0; br_taken = '0; br_target = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset state");

    step(0, '0, 32'h0, 1, "R9 merge with empty store");
    step(1, '1, 32'h0000_1000, 0, "R2 uniform taken redirect");
    step(0, '0, 32'h0, 0, "R11 redirect pulse ends");
    step(1, '0, 32'h0000_2000, 0, "R3 nobody taken");
    step(1, 32'h0000_FFFF, 32'h0000_3000, 0, "R4 split push");
    step(1, 32'h0000_00F0, 32'h0000_4000, 0, "R3 taken bits on disabled lanes");
    step(1, 32'hFFFF_0000, 32'h0000_5000, 0, "R2 uniform inside split");
    step(1, '0, 32'h0000_6000, 1, "R10 branch and merge together");
    step(0, '0, 32'h0, 1, "R5 first merge");
    step(0, '0, 32'h0, 1, "R6 second merge pops");
    step(0, '0, 32'h0, 1, "R9 merge after final pop");

    // R7: eight nested splits, each peeling off one lane
    for (int i = 0; i < DEPTH; i++)
      step(1, LANES'(1) << i, PC_W'(32'h100 * (i + 1)), 0, "R7 nested push");
    step(1, LANES'(1) << DEPTH, 32'h0000_9999, 0, "R8 push when full");
    step(0, '0, 32'h0, 0, "R8 overflow flag sticky");
    for (int i = 0; i < 2 * DEPTH; i++)
      step(0, '0, 32'h0, 1, "R7 nested unwind");
    step(0, '0, 32'h0, 0, "R9 all ones after unwind");

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned op, pat;
      logic [LANES-1:0] bt;
      op  = $urandom_range(0, 9);
      pat = $urandom_range(0, 3);
      case (pat)
        0:       bt = LANES'($urandom());
        1:       bt = '1;
        2:       bt = '0;
        default: bt = m_mask ^ (LANES'(1) << $urandom_range(0, LANES - 1));
      endcase
      if (op < 4)      step(1, bt, PC_W'($urandom()), 0, "RAND branch");
      else if (op < 8) step(0, '0, '0, 1, "RAND merge");
      else if (op < 9) step(1, bt, PC_W'($urandom()), 1, "R10 RAND both");
      else             step(0, '0, '0, 0, "R11 RAND idle");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule